// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block lets software reach the management registers of 10G PHYs over a two-wire management bus: a clock (MDC) generated here and one data line (MDIO) that the master and the PHY take turns driving. Four 32-bit registers sit at word offsets 12 to 15 of a small register window: a status/configuration word, a control word, a data word and a register-address word. Software places the target port and device addresses in the control word. A frame is then launched as a side effect of a register write: writing the register-address word sends an address frame, writing the data word sends a write frame, and writing the control word with its read bit set sends a read frame.

Two separate busy flags report progress. The status word's bus-busy bit covers address frames, and bit 31 of the data word covers write and read frames. A PHY that does not answer a read is detected during the turnaround and reported through a read-error bit, with the returned value forced to all ones. The data line is split into an output, an output enable and an input so that the pad can be placed outside the block.

Top module: `mdio45_master`

## Requirements
- R1: After reset the status word (offset 12) reads 0x0000_0200 with the default divider of 2, and the control (13), data (14) and register-address (15) words read 0. Any other offset reads 0. A read returns data one clock after the offset is presented.
- R2: Status bits 15:8 hold the divider field N, which can be written and read back. During a frame MDC stays high for max(N,1) clocks and then low for max(N,1) clocks.
- R3: A write to offset 15 stores bits 15:0 and sends an address frame (OP 00) that carries them as the payload, using the stored port and device. Status bit 0 is 1 from the cycle after the write until the frame ends, and it is 0 afterwards.
- R4: A write to offset 14 stores bits 15:0 and sends a write frame (OP 01) that carries them. Data bit 31 is 1 while that frame runs, and it is 0 afterwards.
- R5: A write to offset 13 with bit 15 set sends a read frame (OP 11) to port bits 9:5 and device bits 4:0 of the written value. Bit 15 itself reads back as 0.
- R6: A frame consists of 32 ones (left out when control bit 10 is 1), then ST=00, a 2-bit OP, a 5-bit port, a 5-bit device, a 2-bit turnaround (driven as 1 then 0 on address and write frames) and a 16-bit payload, each field sent MSB first.
- R7: MDIO output and output enable change only when MDC falls or when a frame starts, never when MDC rises. While the block is idle, MDC is low and MDIO is not driven. On a read the master releases MDIO for the turnaround and for the 16 data bits.
- R8: On a read in which the PHY drives the second turnaround bit low, data bits 15:0 take the 16 bits that are sampled on the following rising MDC edges, and status bit 1 is 0.
- R9: If the second turnaround bit of a read is not low, status bit 1 is set and data bits 15:0 become 0xFFFF. Status bit 1 clears when the next read frame starts.
- R10: While either busy flag is set, writes to any register are ignored and are not queued. No frame results from them and no register changes.
- R11: Control bit 11 (scan enable) and bit 14 (post-increment) are stored and read back, and they have no effect on frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Word offset to read |
| rd_data | output | 32 | Registered read data, valid one clock after rd_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data value driven by the master |
| mdio_oe | output | 1 | High when the master drives the data line |
| mdio_i | input | 1 | Data line as seen at the pad (pulled up when undriven) |

## Verification
The hardest case to reach is a read in which the turnaround is not driven low. The error path depends on a single sample taken on one rising MDC edge, and the frame that follows must still clear the flag as soon as it starts. The bench's PHY responder answers only one port address, so a read aimed at any other port leaves the line pulled high. The bench then issues a good read with the preamble switched off and reads the status word in the clock cycles just after that read launches. Writes are also placed in the middle of a running frame to show that they are dropped and leave every register unchanged.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int DIV_W      = 8;
  localparam int RX_BITS    = 18;   // turnaround plus data, released on reads

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } mdio_op_e;

  localparam logic [FRAME_BITS-1:0] MASK_ALL  = '1;
  localparam logic [FRAME_BITS-1:0] MASK_READ = {{(FRAME_BITS-RX_BITS){1'b1}}, {RX_BITS{1'b0}}};

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input mdio_op_e    op,
    input logic [4:0]  port,
    input logic [4:0]  dev,
    input logic [15:0] payload
  );
    return {{PRE_BITS{1'b1}}, 2'b00, op, port, dev, 2'b10, payload};
  endfunction
endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen import mdio45_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half;
  logic             tick;

  assign half = (div == '0) ? DIV_W'(1) : div;
  assign tick = run && (cnt == half - DIV_W'(1));
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio45_shifter.sv
module mdio45_shifter import mdio45_pkg::*; (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic [FRAME_BITS-1:0] drive_mask,
  input  logic                  skip_pre,
  input  logic                  is_read,
  input  logic                  rise,
  input  logic                  fall,
  input  logic                  line_i,
  output logic                  active,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic [15:0]           rdata,
  output logic                  rd_fail
);
  localparam logic [POS_W-1:0] POS_TOP   = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] POS_HDR   = POS_W'(FRAME_BITS - PRE_BITS - 1);
  localparam logic [POS_W-1:0] POS_TA2   = POS_W'(16);

  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] first;
  logic [15:0]      cap;
  logic             ta_bad;

  assign first   = skip_pre ? POS_HDR : POS_TOP;
  assign done    = active && fall && (pos == '0);
  assign rdata   = ta_bad ? 16'hFFFF : cap;
  assign rd_fail = ta_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      pos     <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      cap     <= '0;
      ta_bad  <= 1'b0;
    end else if (start) begin
      active  <= 1'b1;
      pos     <= first;
      mdio_o  <= frame[first];
      mdio_oe <= drive_mask[first];
      ta_bad  <= 1'b0;
      cap     <= '0;
    end else if (active) begin
      if (rise && is_read) begin
        if (pos == POS_TA2) ta_bad <= line_i;
        if (pos < POS_TA2)  cap    <= {cap[14:0], line_i};
      end
      if (fall) begin
        if (pos == '0) begin
          active  <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          pos     <= pos - POS_W'(1);
          mdio_o  <= frame[pos - POS_W'(1)];
          mdio_oe <= drive_mask[pos - POS_W'(1)];
        end
      end
    end
  end
endmodule

// File: rtl/mdio45_master.sv
module mdio45_master import mdio45_pkg::*; #(
  parameter int ADDR_W    = 4,
  parameter int REG_BASE  = 12,
  parameter int DIV_RESET = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(REG_BASE + 1);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(REG_BASE + 2);
  localparam logic [ADDR_W-1:0] OFF_ADDR = ADDR_W'(REG_BASE + 3);

  logic [DIV_W-1:0]      div_q;
  logic [4:0]            dev_q, port_q;
  logic                  nopre_q, scan_q, pinc_q;
  logic [15:0]           data_q, addr_q;
  logic                  bus_busy_q, xfer_busy_q, rd_err_q;
  logic                  start_q, read_q, skip_q;
  logic [FRAME_BITS-1:0] frame_q, mask_q;
  logic                  any_busy;

  logic        run, rise, fall, done, rd_fail;
  logic [15:0] rdata;

  assign any_busy = bus_busy_q || xfer_busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q       <= DIV_W'(DIV_RESET);
      dev_q       <= '0;
      port_q      <= '0;
      nopre_q     <= 1'b0;
      scan_q      <= 1'b0;
      pinc_q      <= 1'b0;
      data_q      <= '0;
      addr_q      <= '0;
      bus_busy_q  <= 1'b0;
      xfer_busy_q <= 1'b0;
      rd_err_q    <= 1'b0;
      start_q     <= 1'b0;
      read_q      <= 1'b0;
      skip_q      <= 1'b0;
      frame_q     <= '0;
      mask_q      <= MASK_ALL;
    end else begin
      start_q <= 1'b0;
      if (done) begin
        bus_busy_q  <= 1'b0;
        xfer_busy_q <= 1'b0;
        if (read_q) begin
          data_q   <= rdata;
          rd_err_q <= rd_fail;
        end
      end
      if (wr_en && !any_busy) begin
        unique case (wr_addr)
          OFF_STAT: div_q <= wr_data[15:8];
          OFF_CTRL: begin
            dev_q   <= wr_data[4:0];
            port_q  <= wr_data[9:5];
            nopre_q <= wr_data[10];
            scan_q  <= wr_data[11];
            pinc_q  <= wr_data[14];
            if (wr_data[15]) begin
              frame_q     <= build_frame(OP_READ, wr_data[9:5], wr_data[4:0], 16'hFFFF);
              mask_q      <= MASK_READ;
              read_q      <= 1'b1;
              skip_q      <= wr_data[10];
              start_q     <= 1'b1;
              xfer_busy_q <= 1'b1;
              rd_err_q    <= 1'b0;
            end
          end
          OFF_DATA: begin
            data_q      <= wr_data[15:0];
            frame_q     <= build_frame(OP_WRITE, port_q, dev_q, wr_data[15:0]);
            mask_q      <= MASK_ALL;
            read_q      <= 1'b0;
            skip_q      <= nopre_q;
            start_q     <= 1'b1;
            xfer_busy_q <= 1'b1;
          end
          OFF_ADDR: begin
            addr_q     <= wr_data[15:0];
            frame_q    <= build_frame(OP_ADDR, port_q, dev_q, wr_data[15:0]);
            mask_q     <= MASK_ALL;
            read_q     <= 1'b0;
            skip_q     <= nopre_q;
            start_q    <= 1'b1;
            bus_busy_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        OFF_STAT: rd_data <= {16'h0, div_q, 6'h0, rd_err_q, bus_busy_q};
        OFF_CTRL: rd_data <= {16'h0, 1'b0, pinc_q, 2'b00, scan_q, nopre_q, port_q, dev_q};
        OFF_DATA: rd_data <= {xfer_busy_q, 15'h0, data_q};
        OFF_ADDR: rd_data <= {16'h0, addr_q};
        default:  rd_data <= '0;
      endcase
    end
  end

  mdio45_clkgen u_clk (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .div  (div_q),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdio45_shifter u_shift (
    .clk        (clk),
    .rst        (rst),
    .start      (start_q),
    .frame      (frame_q),
    .drive_mask (mask_q),
    .skip_pre   (skip_q),
    .is_read    (read_q),
    .rise       (rise),
    .fall       (fall),
    .line_i     (mdio_i),
    .active     (run),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .done       (done),
    .rdata      (rdata),
    .rd_fail    (rd_fail)
  );
endmodule

// File: rtl/mdio45_master_chk.sv
module mdio45_master_chk (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        wr_en,
  input logic        bus_busy,
  input logic        xfer_busy,
  input logic [15:0] addr_reg
);
  // R7: outputs hold still across a rising MDC edge
  p_stable_at_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R7: idle bus is quiet
  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_busy || xfer_busy) |-> (!mdio_oe && !mdc));

  // R10: no second access is accepted, so the two flags never overlap
  p_single_busy_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_busy && xfer_busy));

  // R10: writes during a frame leave the address word alone
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (bus_busy || xfer_busy)) |=> $stable(addr_reg));
endmodule

bind mdio45_master mdio45_master_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .wr_en     (wr_en),
  .bus_busy  (bus_busy_q),
  .xfer_busy (xfer_busy_q),
  .addr_reg  (addr_q)
);

// File: tb/sim_mdio45_master.sv
`timescale 1ns/1ps
module sim_mdio45_master;
  localparam int AW = 4;
  localparam logic [4:0] PHY_PORT = 5'd3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          mdc, mdio_o, mdio_oe;
  logic          mdio_i = 1'b1;

  always #2.5 clk = ~clk;

  mdio45_master u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard: {preamble length, 32-bit frame body}
  logic [39:0] exp_q[$];
  string       tag_q[$];

  task automatic expect_frame(input int pre, input logic [1:0] op, input logic [4:0] port,
                              input logic [4:0] dev, input logic [1:0] ta,
                              input logic [15:0] pay, input string req);
    exp_q.push_back({8'(pre), 2'b00, op, port, dev, ta, pay});
    tag_q.push_back(req);
  endtask

  // PHY responder and line monitor
  logic        line;
  assign line = mdio_oe ? mdio_o : mdio_i;
  logic [15:0] phy_val = 16'h0;
  logic [31:0] cap = '0;
  bit          in_frame = 0, resp = 0;
  int          nb = 0, pre = 0, pre_seen = 0;

  always @(posedge mdc) begin
    if (!in_frame) begin
      if (line == 1'b0) begin
        in_frame = 1; nb = 1; cap = 32'h0; pre_seen = pre;
      end else pre = pre + 1;
    end else begin
      cap = {cap[30:0], line};
      nb = nb + 1;
      if (nb == 14) resp = (cap[11:10] == 2'b11) && (cap[9:5] == PHY_PORT);
      if (nb == 32) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected frame", {8'(pre_seen), cap}, 40'h0);
        end else begin
          logic [39:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({8'(pre_seen), cap} == e, t, {8'(pre_seen), cap}, e);
        end
        in_frame = 0; resp = 0; pre = 0;
      end
    end
  end

  always @(negedge mdc) begin
    if (in_frame && resp) begin
      int k;
      k = nb + 1;
      if (k == 16) mdio_i = 1'b0;
      else if (k >= 17 && k <= 32) mdio_i = phy_val[32-k];
      else mdio_i = 1'b1;
    end else mdio_i = 1'b1;
  end

  task automatic reg_write(input int idx, input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_addr = AW'(idx); wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_read(input int idx, output logic [31:0] v);
    @(negedge clk); rd_addr = AW'(idx);
    @(negedge clk); v = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s, d;
    for (int i = 0; i < 4000; i++) begin
      reg_read(12, s);
      reg_read(14, d);
      if (!s[0] && !d[31]) break;
    end
  endtask

  task automatic measure_mdc(input longint exp_ns, input string req);
    longint t0, t1, t2;
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    check((t1 - t0) == exp_ns, {req, " high time"}, 40'(t1 - t0), 40'(exp_ns));
    check((t2 - t1) == exp_ns, {req, " low time"}, 40'(t2 - t1), 40'(exp_ns));
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state and offsets
    reg_read(12, v); check(v == 32'h200, "R1 status reset", 40'(v), 40'h200);
    reg_read(13, v); check(v == 0, "R1 control reset", 40'(v), 40'h0);
    reg_read(14, v); check(v == 0, "R1 data reset", 40'(v), 40'h0);
    reg_read(15, v); check(v == 0, "R1 address reset", 40'(v), 40'h0);
    reg_read(3, v);  check(v == 0, "R1 unmapped offset", 40'(v), 40'h0);

    // R11 scan and post-increment stored, no frame launched
    reg_write(13, 32'h0000_4861);
    reg_read(13, v); check(v == 32'h4861, "R11 control readback", 40'(v), 40'h4861);

    // R3 address frame, R10 writes during it are dropped
    expect_frame(32, 2'b00, 5'd3, 5'd1, 2'b10, 16'hA55A, "R3 R6 address frame");
    reg_write(15, 32'h0000_A55A);
    reg_read(12, v); check(v[0] == 1'b1, "R3 bus busy set", 40'(v[0]), 40'h1);
    reg_read(14, v); check(v[31] == 1'b0, "R3 transfer busy clear", 40'(v[31]), 40'h0);
    reg_write(14, 32'h0000_1234);
    reg_write(13, 32'h0000_0000);
    reg_write(15, 32'h0000_0001);
    wait_idle();
    reg_read(12, v); check(v[0] == 1'b0, "R3 bus busy cleared", 40'(v[0]), 40'h0);
    reg_read(15, v); check(v == 32'hA55A, "R10 address kept", 40'(v), 40'hA55A);
    reg_read(14, v); check(v == 32'h0, "R10 data write ignored", 40'(v), 40'h0);
    reg_read(13, v); check(v == 32'h4861, "R10 control write ignored", 40'(v), 40'h4861);

    // R4 write frame
    expect_frame(32, 2'b01, 5'd3, 5'd1, 2'b10, 16'hBEEF, "R4 R6 write frame");
    reg_write(14, 32'h0000_BEEF);
    reg_read(14, v); check(v[31] == 1'b1, "R4 transfer busy set", 40'(v[31]), 40'h1);
    wait_idle();
    reg_read(14, v); check(v == 32'hBEEF, "R4 data after write", 40'(v), 40'hBEEF);

    // R5 R8 good read
    phy_val = 16'h1C3E;
    expect_frame(32, 2'b11, 5'd3, 5'd1, 2'b10, 16'h1C3E, "R5 R7 read frame");
    reg_write(13, 32'h0000_C861);
    wait_idle();
    reg_read(14, v); check(v == 32'h1C3E, "R8 read data", 40'(v), 40'h1C3E);
    reg_read(12, v); check(v[1] == 1'b0, "R8 no read error", 40'(v[1]), 40'h0);
    reg_read(13, v); check(v == 32'h4861, "R5 read bit reads 0", 40'(v), 40'h4861);

    // R9 absent PHY
    expect_frame(32, 2'b11, 5'd9, 5'd2, 2'b11, 16'hFFFF, "R9 read no answer");
    reg_write(13, 32'h0000_8122);
    wait_idle();
    reg_read(12, v); check(v[1] == 1'b1, "R9 read error set", 40'(v[1]), 40'h1);
    reg_read(14, v); check(v == 32'hFFFF, "R9 data forced", 40'(v), 40'hFFFF);

    // R6 no preamble, R9 error cleared at start
    phy_val = 16'h8001;
    expect_frame(0, 2'b11, 5'd3, 5'd7, 2'b10, 16'h8001, "R6 preamble off read");
    reg_write(13, 32'h0000_8467);
    reg_read(12, v); check(v[1] == 1'b0, "R9 error cleared at read start", 40'(v[1]), 40'h0);
    wait_idle();
    reg_read(14, v); check(v == 32'h8001, "R8 read data no preamble", 40'(v), 40'h8001);

    // R2 divider 4
    reg_write(12, 32'h0000_0400);
    reg_read(12, v); check(v == 32'h400, "R2 divider readback", 40'(v), 40'h400);
    expect_frame(0, 2'b00, 5'd3, 5'd7, 2'b10, 16'h0007, "R2 address frame div4");
    reg_write(15, 32'h0000_0007);
    measure_mdc(20, "R2 div4");
    wait_idle();

    // R2 divider 0 acts as 1
    reg_write(12, 32'h0000_0000);
    expect_frame(0, 2'b01, 5'd3, 5'd7, 2'b10, 16'h0F0F, "R2 write frame div0");
    reg_write(14, 32'h0000_0F0F);
    measure_mdc(5, "R2 div0");
    wait_idle();

    check(exp_q.size() == 0, "R6 all expected frames seen", 40'(exp_q.size()), 40'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule